// File: doc/BRIEF.md
# SDRAM Command Decoder with Per-Bank State Tracking

This block watches the control pins of an SDRAM command bus and, on every rising clock edge, turns the sampled clock-enable, chip-select, row strobe, column strobe and write-enable levels into a one-hot command code. Along with the code it reports the target bank, whether the command covers all banks, and whether auto-precharge was requested. The decode is registered: a command sampled at edge k appears on the outputs right after edge k.

For each bank the block keeps an open or closed state, plus a pending auto-precharge state. It uses these states to flag any command that the current bank state does not allow. An illegal command is still reported on the command output, with a one-cycle `illegal_o` pulse, and it does not change any bank state. The block also models the two data-mask latencies. A read data mask takes effect two clocks after it is sampled. A write data mask applies to the data word sampled at the same edge.

It is meant for bus monitors, protocol checkers and controller self-test logic that need a cycle-exact view of the commands being issued.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: With clock enable high in the previous and current cycle and chip select low, the {row, column, write} strobe levels decode as follows. 011 is activate (bit 2), 101 is read (bit 3), 100 is write (bit 4), 010 is precharge (bit 5), 000 is mode set (bit 6), 001 is auto refresh (bit 7), 110 is burst stop (bit 10) and 111 is no-op (bit 0). The command sampled at edge k is shown one-hot on `cmd_o` right after edge k. After reset `cmd_o` is zero.
- R2: Chip select high decodes as deselect (bit 1) and is never flagged illegal. The strobe levels have no effect on any bank state.
- R3: `bank_o` carries the sampled bank bits. On read or write, A10 high sets `auto_pre_o`. On precharge, A10 high sets `all_banks_o`.
- R4: Activate opens an idle bank. Activate to a bank that is open or pending auto-precharge is illegal and leaves the bank state unchanged.
- R5: Read or write to a bank that is not open is illegal.
- R6: Precharge with A10 low closes the addressed bank. Precharge with A10 high closes every bank. Precharge to a bank pending auto-precharge, with A10 low, is illegal.
- R7: A legal read or write with A10 high at edge k leaves the bank shown active until edge k+BURST_LEN, after which it is idle.
- R8: Mode set, auto refresh, self-refresh entry (pattern 001 with clock enable falling, bit 8) and power-down entry (no-op or deselect with clock enable falling, bit 9) are illegal unless every bank is idle.
- R9: If clock enable was low at the previous edge, nothing is decoded (`cmd_o` is zero) unless clock enable is now high, which decodes as exit (bit 11).
- R10: `rd_mask_o` after edge k equals the data mask input sampled at edge k-2.
- R11: `wr_mask_o` after edge k equals the data mask input sampled at edge k, aligned with the command decoded at that edge.
- R12: `illegal_o` is high for exactly the cycle after the offending edge and clears on the next legal or empty edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable level |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| a10_i | input | 1 | Auto-precharge / all-bank select address bit |
| ba_i | input | BANK_W | Bank select |
| dqm_i | input | 1 | Data mask |
| cmd_o | output | 12 | One-hot decoded command |
| bank_o | output | BANK_W | Target bank of the decoded command |
| all_banks_o | output | 1 | Precharge covers all banks |
| auto_pre_o | output | 1 | Read or write requested auto-precharge |
| illegal_o | output | 1 | Decoded command illegal for current bank state |
| bank_active_o | output | 2**BANK_W | Per-bank not-idle flags |
| rd_mask_o | output | 1 | Read output mask, two-clock latency |
| wr_mask_o | output | 1 | Write data mask, zero-clock latency |

## Verification
The assertions assume that the strobe inputs are stable around each rising edge and hold known values once reset is released. The bench changes every input on the falling edge, so each rising edge sees settled levels. The bank assertions also assume that a precharge never targets a bank in the pending auto-precharge state with A10 low unless it is flagged illegal. The bench keeps this true by only issuing such precharges after the auto-precharge countdown has ended.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  localparam int CMD_W  = 12;
  localparam int C_NOP  = 0;
  localparam int C_DESL = 1;
  localparam int C_ACT  = 2;
  localparam int C_RD   = 3;
  localparam int C_WR   = 4;
  localparam int C_PRE  = 5;
  localparam int C_MRS  = 6;
  localparam int C_AREF = 7;
  localparam int C_SREF = 8;
  localparam int C_PDN  = 9;
  localparam int C_BST  = 10;
  localparam int C_EXIT = 11;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_APRE = 2'd2
  } bank_st_e;
endpackage

// File: rtl/sdram_cmd_classify.sv
module sdram_cmd_classify
  import sdram_dec_pkg::*;
(
  input  logic             cke_prev_i,
  input  logic             cke_i,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  output logic [CMD_W-1:0] cmd_o
);
  always_comb begin
    cmd_o = '0;
    if (!cke_prev_i) begin
      if (cke_i) cmd_o[C_EXIT] = 1'b1;
    end else if (cs_ni) begin
      if (cke_i) cmd_o[C_DESL] = 1'b1;
      else       cmd_o[C_PDN]  = 1'b1;
    end else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b111: begin
          if (cke_i) cmd_o[C_NOP] = 1'b1;
          else       cmd_o[C_PDN] = 1'b1;
        end
        3'b011: cmd_o[C_ACT] = 1'b1;
        3'b101: cmd_o[C_RD]  = 1'b1;
        3'b100: cmd_o[C_WR]  = 1'b1;
        3'b010: cmd_o[C_PRE] = 1'b1;
        3'b000: cmd_o[C_MRS] = 1'b1;
        3'b001: begin
          if (cke_i) cmd_o[C_AREF] = 1'b1;
          else       cmd_o[C_SREF] = 1'b1;
        end
        3'b110: cmd_o[C_BST] = 1'b1;
        default: cmd_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_dec_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_cmd_i,
  input  logic close_cmd_i,
  input  logic ap_cmd_i,
  output logic busy_o,
  output logic open_o
);
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (close_cmd_i) begin
      st_q  <= BK_IDLE;
    end else if (open_cmd_i) begin
      st_q  <= BK_OPEN;
    end else if (ap_cmd_i) begin
      st_q  <= BK_APRE;
      cnt_q <= CNT_W'(BURST_LEN - 1);
    end else if (st_q == BK_APRE) begin
      if (cnt_q == '0) st_q <= BK_IDLE;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (st_q != BK_IDLE);
  assign open_o = (st_q == BK_OPEN);

  assert_close_idles_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_cmd_i |=> !busy_o);
  assert_open_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_cmd_i && !close_cmd_i) |=> open_o);
  assert_ap_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_cmd_i && !close_cmd_i && !open_cmd_i) |=> (busy_o && !open_o));
endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
  parameter int RD_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dqm_i,
  output logic rd_mask_o,
  output logic wr_mask_o
);
  localparam int WARM_W = $clog2(RD_LAT + 2);

  logic [RD_LAT:0]   sh_q;
  logic [WARM_W-1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b0;
    else         sh_q[0] <= dqm_i;
  end

  for (genvar g = 1; g <= RD_LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[g] <= 1'b0;
      else         sh_q[g] <= sh_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                warm_q <= '0;
    else if (warm_q != WARM_W'(RD_LAT + 1))     warm_q <= warm_q + 1'b1;
  end

  assign wr_mask_o = sh_q[0];
  assign rd_mask_o = sh_q[RD_LAT];

  assert_wr_mask_lat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != '0) |-> (wr_mask_o == $past(dqm_i)));

  if (RD_LAT == 2) begin : g_chk2
    assert_rd_mask_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == WARM_W'(3)) |-> (rd_mask_o == $past(dqm_i, 3)));
  end
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_dec_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int BURST_LEN  = 4,
  parameter int RD_DQM_LAT = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cke_i,
  input  logic                     cs_ni,
  input  logic                     ras_ni,
  input  logic                     cas_ni,
  input  logic                     we_ni,
  input  logic                     a10_i,
  input  logic [BANK_W-1:0]        ba_i,
  input  logic                     dqm_i,
  output logic [CMD_W-1:0]         cmd_o,
  output logic [BANK_W-1:0]        bank_o,
  output logic                     all_banks_o,
  output logic                     auto_pre_o,
  output logic                     illegal_o,
  output logic [(1<<BANK_W)-1:0]   bank_active_o,
  output logic                     rd_mask_o,
  output logic                     wr_mask_o
);
  localparam int NB = 1 << BANK_W;

  logic             cke_q;
  logic [CMD_W-1:0] cmd_d;
  logic [NB-1:0]    busy, open, sel;
  logic [NB-1:0]    open_v, close_v, ap_v;
  logic             ill_d, rdwr, global_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  sdram_cmd_classify u_cls (
    .cke_prev_i (cke_q),
    .cke_i      (cke_i),
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .cmd_o      (cmd_d)
  );

  assign sel        = NB'(1) << ba_i;
  assign rdwr       = cmd_d[C_RD] | cmd_d[C_WR];
  assign global_cmd = cmd_d[C_MRS] | cmd_d[C_AREF] | cmd_d[C_SREF] | cmd_d[C_PDN];

  // Legality against the bank state held before this edge
  always_comb begin
    ill_d = 1'b0;
    if (cmd_d[C_ACT])                 ill_d = busy[ba_i];
    else if (rdwr)                    ill_d = !open[ba_i];
    else if (cmd_d[C_PRE] && !a10_i)  ill_d = busy[ba_i] && !open[ba_i];
    else if (global_cmd)              ill_d = |busy;
  end

  always_comb begin
    open_v  = '0;
    close_v = '0;
    ap_v    = '0;
    if (!ill_d) begin
      if (cmd_d[C_ACT])      open_v  = sel;
      if (cmd_d[C_PRE])      close_v = a10_i ? '1 : sel;
      if (rdwr && a10_i)     ap_v    = sel;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdram_bank_fsm #(.BURST_LEN(BURST_LEN)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .open_cmd_i  (open_v[b]),
      .close_cmd_i (close_v[b]),
      .ap_cmd_i    (ap_v[b]),
      .busy_o      (busy[b]),
      .open_o      (open[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= '0;
      bank_o      <= '0;
      all_banks_o <= 1'b0;
      auto_pre_o  <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      cmd_o       <= cmd_d;
      bank_o      <= ba_i;
      all_banks_o <= cmd_d[C_PRE] & a10_i;
      auto_pre_o  <= rdwr & a10_i;
      illegal_o   <= ill_d;
    end
  end

  assign bank_active_o = busy;

  sdram_dqm_pipe #(.RD_LAT(RD_DQM_LAT)) u_dqm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dqm_i     (dqm_i),
    .rd_mask_o (rd_mask_o),
    .wr_mask_o (wr_mask_o)
  );

  assert_cmd_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));
  assert_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_q && cke_i && cs_ni) |=> (cmd_o[C_DESL] && !illegal_o));
  assert_lowpower_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_q && !cke_i) |=> (cmd_o == '0));
  assert_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_q && cke_i) |=> cmd_o[C_EXIT]);
  assert_rdwr_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o[C_RD] || cmd_o[C_WR]) && !illegal_o) |-> bank_active_o[bank_o]);
  assert_act_opens_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[C_ACT] && !illegal_o) |-> bank_active_o[bank_o]);
  assert_global_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o[C_MRS] || cmd_o[C_AREF] || cmd_o[C_SREF] || cmd_o[C_PDN]) && !illegal_o)
      |-> ($past(bank_active_o) == '0));
  assert_illegal_has_cmd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (cmd_o != '0));
  assert_flags_scope_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_pre_o |-> (cmd_o[C_RD] || cmd_o[C_WR])) and (all_banks_o |-> cmd_o[C_PRE]));
endmodule

// File: tb/sdram_cmd_decoder_tb.sv
`timescale 1ns/1ps
module sdram_cmd_decoder_tb;
  localparam int B_NOP = 0, B_DESL = 1, B_ACT = 2, B_RD = 3, B_WR = 4, B_PRE = 5;
  localparam int B_MRS = 6, B_AREF = 7, B_SREF = 8, B_PDN = 9, B_EXIT = 11;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic a10 = 1'b0, dqm = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [11:0] cmd;
  logic [1:0] bank;
  logic all_b, ap, ill, rdm, wrm;
  logic [3:0] act;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .a10_i(a10), .ba_i(ba), .dqm_i(dqm),
    .cmd_o(cmd), .bank_o(bank), .all_banks_o(all_b), .auto_pre_o(ap),
    .illegal_o(ill), .bank_active_o(act), .rd_mask_o(rdm), .wr_mask_o(wrm)
  );

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, a, e);
    end
  endtask

  function automatic logic [31:0] oh(input int b);
    return 32'(1) << b;
  endfunction

  task automatic drive(input logic k, input logic c, input logic r, input logic ca,
                       input logic w, input logic ad, input logic [1:0] b, input logic m);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; a10 = ad; ba = b; dqm = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop();                          drive(1, 0, 1, 1, 1, 0, 0, 0); endtask
  task automatic activate(input logic [1:0] b);  drive(1, 0, 0, 1, 1, 0, b, 0); endtask
  task automatic rd(input logic [1:0] b, input logic p); drive(1, 0, 1, 0, 1, p, b, 0); endtask
  task automatic wr(input logic [1:0] b, input logic p); drive(1, 0, 1, 0, 0, p, b, 0); endtask
  task automatic pre(input logic [1:0] b, input logic p); drive(1, 0, 0, 1, 0, p, b, 0); endtask

  task automatic t_reset();
    chk("R1 reset cmd", 32'(cmd), 0);
    chk("R1 reset banks", 32'(act), 0);
    chk("R12 reset illegal", 32'(ill), 0);
    chk("R10 reset rd mask", 32'(rdm), 0);
  endtask

  task automatic t_activate();
    activate(2'd1);
    chk("R1 act code", 32'(cmd), oh(B_ACT));
    chk("R4 act opens", 32'(act), 32'h2);
    chk("R4 act legal", 32'(ill), 0);
    activate(2'd1);
    chk("R4 act on open illegal", 32'(ill), 1);
    chk("R4 act on open unchanged", 32'(act), 32'h2);
    nop();
    chk("R12 illegal one cycle", 32'(ill), 0);
    chk("R1 nop code", 32'(cmd), oh(B_NOP));
  endtask

  task automatic t_rdwr();
    rd(2'd0, 0);
    chk("R5 read idle bank illegal", 32'(ill), 1);
    chk("R1 read code", 32'(cmd), oh(B_RD));
    rd(2'd1, 0);
    chk("R5 read open legal", 32'(ill), 0);
    chk("R3 no auto-pre", 32'(ap), 0);
    chk("R3 bank out", 32'(bank), 1);
    wr(2'd1, 1);
    chk("R1 write code", 32'(cmd), oh(B_WR));
    chk("R3 auto-pre flag", 32'(ap), 1);
    chk("R7 active after ap cmd", 32'(act), 32'h2);
    nop(); nop(); nop();
    chk("R7 active at k+3", 32'(act), 32'h2);
    nop();
    chk("R7 idle at k+BL", 32'(act), 0);
    wr(2'd1, 0);
    chk("R5 write after ap illegal", 32'(ill), 1);
  endtask

  task automatic t_precharge();
    activate(2'd0); activate(2'd2); activate(2'd3);
    chk("R4 three open", 32'(act), 32'hD);
    pre(2'd2, 0);
    chk("R1 pre code", 32'(cmd), oh(B_PRE));
    chk("R6 single close", 32'(act), 32'h9);
    chk("R3 single not all", 32'(all_b), 0);
    chk("R3 pre bank", 32'(bank), 2);
    pre(2'd0, 1);
    chk("R3 all flag", 32'(all_b), 1);
    chk("R6 all close", 32'(act), 0);
  endtask

  task automatic t_global();
    activate(2'd0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 mode set busy illegal", 32'(ill), 1);
    drive(1, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 refresh busy illegal", 32'(ill), 1);
    chk("R1 refresh code", 32'(cmd), oh(B_AREF));
    pre(2'd0, 1);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 mode set code", 32'(cmd), oh(B_MRS));
    chk("R8 mode set idle legal", 32'(ill), 0);
    drive(1, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 refresh idle legal", 32'(ill), 0);
  endtask

  task automatic t_deselect();
    activate(2'd3);
    drive(1, 1, 0, 1, 1, 0, 2'd0, 0);
    chk("R2 deselect code", 32'(cmd), oh(B_DESL));
    chk("R2 deselect banks unchanged", 32'(act), 32'h8);
    chk("R2 deselect legal", 32'(ill), 0);
    pre(2'd0, 1);
  endtask

  task automatic t_cke();
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 self refresh code", 32'(cmd), oh(B_SREF));
    chk("R8 self refresh legal", 32'(ill), 0);
    drive(0, 0, 0, 1, 1, 0, 2'd2, 0);
    chk("R9 suppressed cmd", 32'(cmd), 0);
    chk("R9 suppressed banks", 32'(act), 0);
    drive(1, 0, 1, 1, 1, 0, 0, 0);
    chk("R9 exit code", 32'(cmd), oh(B_EXIT));
    nop();
    chk("R9 decode resumes", 32'(cmd), oh(B_NOP));
    activate(2'd1);
    drive(0, 1, 1, 1, 1, 0, 0, 0);
    chk("R8 power-down code", 32'(cmd), oh(B_PDN));
    chk("R8 power-down busy illegal", 32'(ill), 1);
    drive(0, 1, 1, 1, 1, 0, 0, 0);
    chk("R9 held low", 32'(cmd), 0);
    drive(1, 0, 1, 1, 1, 0, 0, 0);
    chk("R9 exit after pd", 32'(cmd), oh(B_EXIT));
    pre(2'd0, 1);
  endtask

  task automatic t_dqm();
    logic [7:0] pat = 8'b0001_1001;
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, 1, 1, 1, 0, 0, pat[i]);
      chk("R11 write mask same edge", 32'(wrm), 32'(pat[i]));
      chk("R10 read mask two later", 32'(rdm), (i >= 2) ? 32'(pat[i-2]) : 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_activate();
    t_rdwr();
    t_precharge();
    t_global();
    t_deselect();
    t_cke();
    t_dqm();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule